// File: doc/BRIEF.md
# Sleep-State Wake Event Qualifier

This block decides, while the system sleeps in one of the states S1 to S5, which incoming events are allowed to bring it back to the working state. Each event source is qualified against three things: its own enable bit (unless the source is permanently enabled), the current sleep depth, which also stands for which power well is still powered, and, in S5, the reason S5 was entered. An S5 reached through a power-button override or a thermal trip accepts only a small set of events. A qualified rising edge of a source sets that source's sticky status bit. The first qualified event of a sleep period also raises a single one-cycle wake request, which the power sequencer uses.

All event sources share one bit layout on the event, enable, clear and status vectors. Software clears status bits by writing ones to the clear strobe vector. The general-purpose input count, the USB controller count, which general-purpose inputs sit in the core well, and whether a set or a clear wins when both happen in one cycle are all parameters.

Top module: `wake_qualifier`

## Requirements
- R1: After reset every status bit and the wake request are 0. While the sleep state input is 0 (working state; 1 to 5 encode S1 to S5), no event sets a status bit and no wake request is produced.
- R2: A rising edge on the power-button source wakes the system from S1 through S5 whatever its enable bit holds.
- R3: The RTC alarm, ring indicate, audio, both PME lines, each of the four USB controllers, the SMBus alert, the SMBus host-notify and the PCI Express wake pin act only when their own enable bit is 1.
- R4: General-purpose inputs 0 to 7 and 12 (core well) qualify only in S1. Inputs 8 to 11 and 13 to 15 (resume well) qualify in S1 through S5. Every general-purpose input also needs its enable bit.
- R5: A PCI Express PME message qualifies only in S1.
- R6: The S5 cause input is encoded 0 software request, 1 power failure, 2 power-button override, 3 thermal trip. In S5 with cause 2 or 3, only the power button and the two SMBus hard-reset commands qualify.
- R7: In S5 the PCI Express wake pin qualifies when the cause is 0 or 1, given its enable bit. In S1 to S4 it qualifies given its enable bit.
- R8: The SMBus slave wake command and both SMBus hard-reset commands need no enable bit and qualify in S1 through S5.
- R9: A status bit goes to 1 in the cycle after a qualified rising edge of its source and stays 1 until a 1 arrives on its clear strobe. A level that is held high does not set the bit again after a clear. If a set and a clear coincide, the set wins.
- R10: The wake request is a one-cycle pulse, issued in the cycle after the first qualified event following entry to sleep from state 0. Later events, including those after moves between sleep states, do not pulse again until state 0 has been visited.
- R11: The cause is sampled in the cycle the state becomes S5 and is held until the state returns to 0. Changes on the cause input during S5 have no effect.
- R12: The bit layout of the event, enable, clear and status vectors is: 0 power button, 1 RTC, 2 ring indicate, 3 audio, 4 PME line A, 5 PME line B, 6 PCI Express wake pin, 7 PCI Express PME message, 8 SMBus alert, 9 SMBus slave wake, 10 SMBus host-notify, 11 hard reset without cycling, 12 hard reset system, 13+n general-purpose input n, 29+k USB controller k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slp_state_i | input | 3 | Current sleep state, 0 = working, 1 to 5 = S1 to S5 |
| s5_why_i | input | 2 | Reason for entering S5, sampled on S5 entry |
| evt_i | input | NSRC (33) | Raw event levels, bit layout per R12 |
| wake_en_i | input | NSRC (33) | Per-source wake enables; ignored for always-on sources |
| sts_clr_i | input | NSRC (33) | Write-one-to-clear strobes for the status bits |
| sts_o | output | NSRC (33) | Sticky per-source wake status |
| wake_req_o | output | 1 | One-cycle wake request |

## Verification
The hardest case to reach is a change of the S5 cause input while the system is already in S5. This must have no effect, and it can only be seen by firing a cause-sensitive source, the PCI Express wake pin, after the change. The stimulus enters S5 with one cause, flips the cause input, then pulses the wake pin and checks the status that results. It does this in both directions. The bench also stays in one sleep period across moves between S1, S3 and S5 to show that the wake request is not issued again. A reference model compares status and request on every cycle, both during directed phases and during a long pseudo-random phase.

// File: rtl/wq_pkg.sv
package wq_pkg;

   typedef enum logic [2:0] {
      SLP_S0 = 3'd0,
      SLP_S1 = 3'd1,
      SLP_S2 = 3'd2,
      SLP_S3 = 3'd3,
      SLP_S4 = 3'd4,
      SLP_S5 = 3'd5
   } slp_e;

   typedef enum logic [1:0] {
      S5_BY_SW    = 2'd0,
      S5_BY_PFAIL = 2'd1,
      S5_BY_PBOVR = 2'd2,
      S5_BY_THERM = 2'd3
   } s5why_e;

   localparam int SRC_PWRBTN   = 0;
   localparam int SRC_RTC      = 1;
   localparam int SRC_RING     = 2;
   localparam int SRC_AUDIO    = 3;
   localparam int SRC_PME_A    = 4;
   localparam int SRC_PME_B    = 5;
   localparam int SRC_PX_PIN   = 6;
   localparam int SRC_PX_MSG   = 7;
   localparam int SRC_SMB_ALRT = 8;
   localparam int SRC_SMB_WAKE = 9;
   localparam int SRC_SMB_HN   = 10;
   localparam int SRC_HRST_NC  = 11;
   localparam int SRC_HRST_SYS = 12;
   localparam int FIXED_SRCS   = 13;

   function automatic logic is_sleeping(logic [2:0] st);
      return (st >= SLP_S1) && (st <= SLP_S5);
   endfunction

endpackage

// File: rtl/wq_policy.sv
module wq_policy
   import wq_pkg::*;
#(
   parameter int          NUM_GPI       = 16,
   parameter int          NUM_USB       = 4,
   parameter logic [31:0] GPI_CORE_MASK = 32'h0000_10FF,
   localparam int         GPI_BASE      = FIXED_SRCS,
   localparam int         NSRC          = FIXED_SRCS + NUM_GPI + NUM_USB
) (
   input  logic [2:0]      state_i,
   input  logic [1:0]      why_i,
   input  logic [NSRC-1:0] en_i,
   output logic [NSRC-1:0] qual_o
);

   function automatic bit core_gpi(int idx);
      if (idx >= GPI_BASE && idx < GPI_BASE + NUM_GPI)
         return GPI_CORE_MASK[5'(idx - GPI_BASE)];
      return 1'b0;
   endfunction

   logic sleeping;
   logic in_s1;
   logic ovr_lock;

   assign sleeping = is_sleeping(state_i);
   assign in_s1    = (state_i == SLP_S1);
   assign ovr_lock = (state_i == SLP_S5) &&
                     ((why_i == S5_BY_PBOVR) || (why_i == S5_BY_THERM));

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam bit ALWAYS_ON = (i == SRC_PWRBTN) || (i == SRC_SMB_WAKE) ||
                                 (i == SRC_HRST_NC) || (i == SRC_HRST_SYS);
      localparam bit S1_ONLY   = (i == SRC_PX_MSG) || core_gpi(i);
      localparam bit OVR_OK    = (i == SRC_PWRBTN) || (i == SRC_HRST_NC) ||
                                 (i == SRC_HRST_SYS);
      assign qual_o[i] = sleeping &&
                         (ALWAYS_ON || en_i[i]) &&
                         (!S1_ONLY || in_s1) &&
                         (!ovr_lock || OVR_OK);
   end

endmodule

// File: rtl/wq_status_bank.sv
module wq_status_bank #(
   parameter int N        = 33,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] qual_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] sts_o,
   output logic [N-1:0] hit_o
);

   logic [N-1:0] evt_q;
   logic [N-1:0] sts_q;
   logic [N-1:0] sts_d;

   assign hit_o = evt_i & ~evt_q & qual_i;

   if (SET_WINS) begin : g_set_first
      assign sts_d = (sts_q & ~clr_i) | hit_o;
   end else begin : g_clr_first
      assign sts_d = (sts_q | hit_o) & ~clr_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         evt_q <= '0;
         sts_q <= '0;
      end else begin
         evt_q <= evt_i;
         sts_q <= sts_d;
      end
   end

   assign sts_o = sts_q;

   AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0)); // R9

   AST_STS_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (((sts_q & ~$past(sts_q)) & ~$past(evt_i)) == '0)); // R9

endmodule

// File: rtl/wq_wake_ctrl.sv
module wq_wake_ctrl
   import wq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] state_i,
   input  logic [1:0] why_i,
   input  logic       hit_any_i,
   output logic [1:0] eff_why_o,
   output logic       wake_req_o
);

   logic [2:0] prev_state_q;
   logic [1:0] why_q;
   logic       armed_q;
   logic       req_q;
   logic       s5_entry;
   logic       fire;

   assign s5_entry  = (state_i == SLP_S5) && (prev_state_q != SLP_S5);
   assign eff_why_o = s5_entry ? why_i : why_q;
   assign fire      = armed_q && is_sleeping(state_i) && hit_any_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_state_q <= SLP_S0;
         why_q        <= S5_BY_SW;
         armed_q      <= 1'b1;
         req_q        <= 1'b0;
      end else begin
         prev_state_q <= state_i;
         if (state_i == SLP_S0)
            why_q <= S5_BY_SW;
         else if (s5_entry)
            why_q <= why_i;
         if (state_i == SLP_S0)
            armed_q <= 1'b1;
         else if (fire)
            armed_q <= 1'b0;
         req_q <= fire;
      end
   end

   assign wake_req_o = req_q;

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_req_o |=> !wake_req_o); // R10

   AST_NO_REQ_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i == SLP_S0) |=> !wake_req_o); // R1

   AST_CAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_i == SLP_S5) && !s5_entry) |=> $stable(why_q)); // R11

endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
   import wq_pkg::*;
#(
   parameter int          NUM_GPI       = 16,
   parameter int          NUM_USB       = 4,
   parameter logic [31:0] GPI_CORE_MASK = 32'h0000_10FF,
   parameter bit          SET_WINS      = 1'b1,
   localparam int         GPI_BASE      = FIXED_SRCS,
   localparam int         NSRC          = FIXED_SRCS + NUM_GPI + NUM_USB
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [2:0]      slp_state_i,
   input  logic [1:0]      s5_why_i,
   input  logic [NSRC-1:0] evt_i,
   input  logic [NSRC-1:0] wake_en_i,
   input  logic [NSRC-1:0] sts_clr_i,
   output logic [NSRC-1:0] sts_o,
   output logic            wake_req_o
);

   if (NUM_GPI < 1 || NUM_GPI > 32) begin : g_bad_gpi
      $error("wake_qualifier: NUM_GPI must lie in 1..32");
   end
   if (NUM_USB < 1 || NUM_USB > 8) begin : g_bad_usb
      $error("wake_qualifier: NUM_USB must lie in 1..8");
   end

   function automatic logic [NSRC-1:0] core_sel();
      logic [NSRC-1:0] m = '0;
      for (int g = 0; g < NUM_GPI; g++)
         if (GPI_CORE_MASK[g]) m[GPI_BASE + g] = 1'b1;
      return m;
   endfunction

   localparam logic [NSRC-1:0] CORE_SEL = core_sel();
   localparam logic [NSRC-1:0] OVR_SEL  = NSRC'((1 << SRC_PWRBTN) |
                                                (1 << SRC_HRST_NC) |
                                                (1 << SRC_HRST_SYS));

   logic [1:0]      eff_why;
   logic [NSRC-1:0] qual;
   logic [NSRC-1:0] hit;

   wq_policy #(
      .NUM_GPI       (NUM_GPI),
      .NUM_USB       (NUM_USB),
      .GPI_CORE_MASK (GPI_CORE_MASK)
   ) u_policy (
      .state_i (slp_state_i),
      .why_i   (eff_why),
      .en_i    (wake_en_i),
      .qual_o  (qual)
   );

   wq_status_bank #(
      .N        (NSRC),
      .SET_WINS (SET_WINS)
   ) u_status (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i),
      .qual_i (qual),
      .clr_i  (sts_clr_i),
      .sts_o  (sts_o),
      .hit_o  (hit)
   );

   wq_wake_ctrl u_wake (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .state_i    (slp_state_i),
      .why_i      (s5_why_i),
      .hit_any_i  (|hit),
      .eff_why_o  (eff_why),
      .wake_req_o (wake_req_o)
   );

   AST_CORE_GPI_DEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((slp_state_i >= SLP_S2) && (slp_state_i <= SLP_S5))
      |=> ((sts_o & ~$past(sts_o) & CORE_SEL) == '0)); // R4

   AST_PX_MSG_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slp_state_i != SLP_S1)
      |=> !(sts_o[SRC_PX_MSG] && !$past(sts_o[SRC_PX_MSG]))); // R5

   AST_OVR_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((slp_state_i == SLP_S5) &&
       ((eff_why == S5_BY_PBOVR) || (eff_why == S5_BY_THERM)))
      |=> ((sts_o & ~$past(sts_o) & ~OVR_SEL) == '0)); // R6

endmodule

// File: tb/wake_qualifier_tb.sv
`timescale 1ns/1ps
module wake_qualifier_tb;

   localparam int NSRC = 33;
   localparam int GB   = 13;
   localparam int UB   = 29;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      state = 3'd0;
   logic [1:0]      why = 2'd0;
   logic [NSRC-1:0] evt = '0;
   logic [NSRC-1:0] en = '0;
   logic [NSRC-1:0] clr = '0;
   logic [NSRC-1:0] sts;
   logic            wreq;

   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_req  = "R1";
   bit    done     = 1'b0;

   always #2 clk = ~clk;

   wake_qualifier u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .slp_state_i (state),
      .s5_why_i    (why),
      .evt_i       (evt),
      .wake_en_i   (en),
      .sts_clr_i   (clr),
      .sts_o       (sts),
      .wake_req_o  (wreq)
   );

   // reference model
   logic [NSRC-1:0] m_sts = '0;
   logic [NSRC-1:0] m_prev_evt = '0;
   int              m_prev_state = 0;
   int              m_cause = 0;
   bit              m_armed = 1'b1;
   bit              m_wake = 1'b0;

   function automatic bit m_allowed(int s, int st, int cz, logic [NSRC-1:0] e);
      int g;
      if (st < 1 || st > 5) return 1'b0;
      if (st == 5 && cz >= 2) return (s == 0) || (s == 11) || (s == 12);
      if (s == 0 || s == 9 || s == 11 || s == 12) return 1'b1;
      if (s == 7) return e[s] && (st == 1);
      if (s >= GB && s < UB) begin
         g = s - GB;
         if (g <= 7 || g == 12) return e[s] && (st == 1);
      end
      return e[s];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sts = '0; m_prev_evt = '0; m_prev_state = 0;
         m_cause = 0; m_armed = 1'b1; m_wake = 1'b0;
      end else begin
         int  st;
         int  cz;
         bit  entry;
         logic [NSRC-1:0] newset;
         st = int'(state);
         entry = (st == 5) && (m_prev_state != 5);
         cz = entry ? int'(why) : m_cause;
         newset = '0;
         for (int s = 0; s < NSRC; s++)
            if (evt[s] && !m_prev_evt[s] && m_allowed(s, st, cz, en))
               newset[s] = 1'b1;
         m_sts = (m_sts & ~clr) | newset;
         m_wake = m_armed && (st >= 1) && (st <= 5) && (newset != '0);
         if (st == 0) m_armed = 1'b1;
         else if (m_wake) m_armed = 1'b0;
         if (st == 0) m_cause = 0;
         else if (entry) m_cause = int'(why);
         m_prev_evt = evt;
         m_prev_state = st;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_checks++;
         if (sts !== m_sts) begin
            n_fails++;
            $display("FAIL %s status got %h expected %h", cur_req, sts, m_sts);
         end
         n_checks++;
         if (wreq !== m_wake) begin
            n_fails++;
            $display("FAIL %s wake_req got %b expected %b", cur_req, wreq, m_wake);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(int s);
      evt[s] = 1'b1;
      step(2);
      evt[s] = 1'b0;
      step(2);
   endtask

   task automatic go(int st, int cz);
      state = 3'(st);
      why = 2'(cz);
      step(2);
   endtask

   task automatic clear_all();
      clr = '1;
      step(1);
      clr = '0;
      step(1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
   end

   initial begin
      int lfsr;
      step(5);
      rst_n = 1'b1;
      step(2);

      // R1: events in working state are ignored
      cur_req = "R1";
      en = '1;
      for (int s = 0; s < NSRC; s++) pulse(s);

      // R2: power button with no enable, every sleep state
      cur_req = "R2";
      en = '0;
      for (int st = 1; st <= 5; st++) begin
         go(st, 0);
         pulse(0);
         clear_all();
         go(0, 0);
      end

      // R3: enable-gated sources, first disabled then enabled
      cur_req = "R3";
      go(3, 0);
      for (int s = 1; s < NSRC; s++) if (s != 7 && !(s >= GB && s < UB)) pulse(s);
      en = '1;
      for (int s = 1; s < NSRC; s++) if (s != 7 && !(s >= GB && s < UB)) pulse(s);
      for (int k = 0; k < 4; k++) begin
         en = '0; en[UB + k] = 1'b1;
         for (int j = 0; j < 4; j++) pulse(UB + j);
      end
      clear_all();
      go(0, 0);

      // R4: core and resume general-purpose inputs
      cur_req = "R4";
      en = '1;
      go(1, 0);
      for (int g = 0; g < 16; g++) pulse(GB + g);
      clear_all();
      go(3, 0);
      for (int g = 0; g < 16; g++) pulse(GB + g);
      clear_all();
      go(0, 0);

      // R5: PME message only in S1
      cur_req = "R5";
      for (int st = 1; st <= 5; st++) begin
         go(st, 0);
         pulse(7);
         clear_all();
      end
      go(0, 0);

      // R6: override and thermal S5 entry restrict the sources
      cur_req = "R6";
      for (int cz = 2; cz <= 3; cz++) begin
         go(5, cz);
         for (int s = 1; s < NSRC; s++) if (s != 11 && s != 12) pulse(s);
         pulse(11);
         pulse(12);
         pulse(0);
         clear_all();
         go(0, 0);
      end

      // R7: wake pin in S5 for software and power-failure entry
      cur_req = "R7";
      for (int cz = 0; cz <= 3; cz++) begin
         go(5, cz);
         pulse(6);
         clear_all();
         go(0, 0);
      end
      go(4, 3);
      pulse(6);
      clear_all();
      go(0, 0);

      // R8: always-on SMBus commands
      cur_req = "R8";
      en = '0;
      go(5, 0);
      pulse(9); pulse(11); pulse(12);
      clear_all();
      go(2, 0);
      pulse(9);
      clear_all();
      go(0, 0);

      // R9: sticky bits, held level, set against clear
      cur_req = "R9";
      en = '1;
      go(1, 0);
      evt[1] = 1'b1;
      step(3);
      clr[1] = 1'b1; step(1); clr[1] = 1'b0;
      step(4);
      evt[1] = 1'b0;
      step(2);
      evt[2] = 1'b1; clr[2] = 1'b1;
      step(1);
      clr[2] = 1'b0; evt[2] = 1'b0;
      step(3);
      clear_all();
      go(0, 0);

      // R10: one pulse per sleep period
      cur_req = "R10";
      go(1, 0);
      pulse(1); pulse(2);
      go(3, 0);
      pulse(3);
      go(5, 0);
      pulse(0);
      go(0, 0);
      go(3, 0);
      pulse(4);
      clear_all();
      go(0, 0);

      // R11: cause held through S5
      cur_req = "R11";
      go(5, 0);
      why = 2'd2;
      step(3);
      pulse(6);
      clear_all();
      go(0, 0);
      go(5, 3);
      why = 2'd0;
      step(3);
      pulse(6);
      pulse(0);
      clear_all();
      go(0, 0);

      // R12: bit layout under mixed traffic
      cur_req = "R12";
      lfsr = 32'h1ACE_5EED;
      for (int c = 0; c < 6000; c++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >>> 17);
         lfsr = lfsr ^ (lfsr << 5);
         if (c % 150 == 0) begin
            state = 3'((lfsr >>> 4) % 6 < 0 ? 0 : ((lfsr >>> 4) & 32'h7FFF_FFFF) % 6);
            en = {lfsr[0], lfsr};
         end
         why = lfsr[9:8];
         evt[((lfsr >>> 11) & 32'h7FFF_FFFF) % NSRC] ^= 1'b1;
         clr = (c % 37 == 0) ? {1'b1, lfsr} : '0;
         step(1);
      end
      clr = '0;
      evt = '0;
      step(5);

      finish_run();
   end

endmodule